// File: doc/BRIEF.md
# Accumulator Machine Memory-Operation Executor

This block carries out the execute phase of the memory-operand instructions of a small accumulator machine. Once an instruction has been fetched and its effective address resolved, a one-cycle `start` pulse hands over a 3-bit operation code and a 12-bit address. The block then runs that operation's fixed schedule of register transfers, one per clock, through timing steps 4, 5 and 6 of a 4-bit step counter. It ends by clearing the counter and pulsing `done`.

The block holds the 16-bit accumulator, the 16-bit data register, the carry flag, the 12-bit program counter and the 12-bit address register. It also holds a single-port word memory with a combinational read and a write on the clock edge. All architectural registers are visible on output ports. The memory request lines are brought out as well, so a surrounding sequencer or a test can follow every transfer.

Top module: `mref_exec`

## Requirements
- R1: While reset is low and for two clock edges after it rises, step, acc, data_reg, carry, pc, addr_reg, done, mem_rd and mem_wr are all zero.
- R2: A start pulse taken while step is 0 loads addr_reg from start_addr and makes step 4 at the next edge. A start pulse while step is non-zero has no effect.
- R3: Opcode 000 (mask): at step 4, mem_rd is 1 and data_reg takes the word at addr_reg. At step 5, acc becomes acc AND data_reg and the instruction ends.
- R4: Opcode 001 (add): at step 4 the word is read into data_reg. At step 5, acc takes the low 16 bits of acc + data_reg and carry takes bit 16 of that sum, in the same edge, and the instruction ends.
- R5: Opcode 010 (load): at step 4 the word is read into data_reg. At step 5, acc takes data_reg and the instruction ends.
- R6: Opcode 011 (store): at step 4, mem_wr is 1, mem_wdata equals acc, and the instruction ends.
- R7: Opcode 100 (jump): at step 4, pc takes addr_reg and the instruction ends.
- R8: Opcode 101 (call): at step 4 the block writes pc, zero-extended, to the word at addr_reg, and addr_reg increments modulo 4096. At step 5, pc takes addr_reg and the instruction ends, so pc finishes at the original address plus one, modulo 4096.
- R9: Opcode 110 (increment-and-skip): at step 4 the word is read into data_reg. At step 5, data_reg increments modulo 65536. At step 6 the block writes data_reg back to the same address, increments pc if data_reg is zero, and ends the instruction.
- R10: Opcode 111 ends at step 4 and changes no register and no memory word.
- R11: done is high for exactly the one cycle in which an instruction ends, and step is 0 in the next cycle. Between start and that end, step advances by one each cycle.
- R12: mem_addr always equals addr_reg. The memory word selected is given by the low 10 address bits. A write commits at its clock edge and is returned by any later read of the same index.
- R13: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction (taken only when step is 0) |
| start_op | input | 3 | Operation code for the instruction being started |
| start_addr | input | 12 | Effective address loaded into addr_reg on start |
| done | output | 1 | High in the cycle that ends the instruction |
| step | output | 4 | Current timing step (0 when idle) |
| acc | output | 16 | Accumulator |
| data_reg | output | 16 | Data register |
| carry | output | 1 | Carry out of the last add |
| pc | output | 12 | Program counter |
| addr_reg | output | 12 | Address register |
| mem_rd | output | 1 | Memory read in this cycle |
| mem_wr | output | 1 | Memory write at the end of this cycle |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |

## Verification
Every architectural register is a port, so a wrong transfer in a register shows up at the very next clock edge, in the step where the schedule fires. A wrong memory word stays hidden until a later load, mask, add or increment reads it back. The bench therefore always reads stored values back through acc, and it uses a memory index that aliases another. A wrong step sequence shows at once in step, done and the read and write strobes, and this includes a start pulse that is wrongly accepted mid-instruction.

// File: rtl/mref_pkg.sv
package mref_pkg;

  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int SC_W    = 4;
  localparam int OP_W    = 3;
  localparam int T_FIRST = 4;
  localparam int T_LAST  = 6;

  typedef enum logic [2:0] {
    OP_MASK    = 3'd0,
    OP_SUM     = 3'd1,
    OP_LOAD    = 3'd2,
    OP_STORE   = 3'd3,
    OP_JUMP    = 3'd4,
    OP_CALL    = 3'd5,
    OP_INCSKIP = 3'd6,
    OP_UNUSED  = 3'd7
  } mref_op_e;

  typedef enum logic [1:0] {
    WSRC_ACC = 2'd0,
    WSRC_PC  = 2'd1,
    WSRC_DR  = 2'd2
  } wsrc_e;

  typedef struct packed {
    logic  dr_from_mem;
    logic  dr_incr;
    logic  acc_mask;
    logic  acc_sum;
    logic  acc_copy;
    logic  pc_from_ar;
    logic  pc_skip;
    logic  ar_incr;
    logic  mem_rd;
    logic  mem_wr;
    wsrc_e wsrc;
    logic  finish;
  } uop_t;

endpackage

// File: rtl/mref_rst_sync.sv
module mref_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mref_ctrl.sv
module mref_ctrl
  import mref_pkg::*;
#(
  parameter int SC_BITS = SC_W,
  parameter int OPB     = OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [OPB-1:0]     start_op,
  output logic [SC_BITS-1:0] step,
  output logic [OPB-1:0]     op,
  output logic               accept,
  output uop_t               uop
);
  localparam int NOP = 1 << OPB;

  logic [SC_BITS-1:0]   sc_q, sc_d;
  logic                 sc_en;
  logic [OPB-1:0]       op_q;
  logic                 idle;
  logic [T_LAST:T_FIRST] t;
  logic [NOP-1:0]       d;

  assign idle = (sc_q == '0);

  // one decoded line per timing step that carries work
  for (genvar j = T_FIRST; j <= T_LAST; j++) begin : g_step
    assign t[j] = (sc_q == SC_BITS'(j));
  end

  // one decoded line per operation code
  for (genvar k = 0; k < NOP; k++) begin : g_op
    assign d[k] = (op_q == OPB'(k));
  end

  assign accept = start & idle;

  always_comb begin
    uop             = '0;
    uop.mem_rd      = t[4] & (d[OP_MASK] | d[OP_SUM] | d[OP_LOAD] | d[OP_INCSKIP]);
    uop.dr_from_mem = uop.mem_rd;
    uop.dr_incr     = t[5] & d[OP_INCSKIP];
    uop.acc_mask    = t[5] & d[OP_MASK];
    uop.acc_sum     = t[5] & d[OP_SUM];
    uop.acc_copy    = t[5] & d[OP_LOAD];
    uop.mem_wr      = (t[4] & (d[OP_STORE] | d[OP_CALL])) | (t[6] & d[OP_INCSKIP]);
    uop.pc_from_ar  = (t[4] & d[OP_JUMP]) | (t[5] & d[OP_CALL]);
    uop.pc_skip     = t[6] & d[OP_INCSKIP];
    uop.ar_incr     = t[4] & d[OP_CALL];
    uop.wsrc        = d[OP_STORE] ? WSRC_ACC : (d[OP_CALL] ? WSRC_PC : WSRC_DR);
    uop.finish      = (t[5] & (d[OP_MASK] | d[OP_SUM] | d[OP_LOAD] | d[OP_CALL]))
                    | (t[4] & (d[OP_STORE] | d[OP_JUMP] | d[OP_UNUSED]))
                    | (t[6] & d[OP_INCSKIP]);
  end

  always_comb begin
    sc_d  = sc_q;
    sc_en = 1'b0;
    if (accept) begin
      sc_d  = SC_BITS'(T_FIRST);
      sc_en = 1'b1;
    end else if (uop.finish) begin
      sc_d  = '0;
      sc_en = 1'b1;
    end else if (!idle) begin
      sc_d  = sc_q + 1'b1;
      sc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
      op_q <= '0;
    end else begin
      if (sc_en)  sc_q <= sc_d;
      if (accept) op_q <= start_op;
    end
  end

  assign step = sc_q;
  assign op   = op_q;
endmodule

// File: rtl/mref_mem.sv
module mref_mem #(
  parameter int W   = 16,
  parameter int IDX = 10
) (
  input  logic           clk,
  input  logic           we,
  input  logic [IDX-1:0] idx,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
  end

  assign rdata = store[idx];
endmodule

// File: rtl/mref_dp.sv
module mref_dp
  import mref_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int A = ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  uop_t         uop,
  input  logic         accept,
  input  logic [A-1:0] start_addr,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] acc,
  output logic [W-1:0] dr,
  output logic         link,
  output logic [A-1:0] pc,
  output logic [A-1:0] ar,
  output logic [W-1:0] wdata
);
  logic [W-1:0] acc_q, acc_d, dr_q, dr_d;
  logic         link_q, link_d;
  logic [A-1:0] pc_q, pc_d, ar_q, ar_d;
  logic         acc_en, dr_en, link_en, pc_en, ar_en;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, dr_q};

  always_comb begin
    acc_en  = uop.acc_mask | uop.acc_sum | uop.acc_copy;
    if (uop.acc_mask)     acc_d = acc_q & dr_q;
    else if (uop.acc_sum) acc_d = sum[W-1:0];
    else                  acc_d = dr_q;

    link_en = uop.acc_sum;
    link_d  = sum[W];

    dr_en   = uop.dr_from_mem | uop.dr_incr;
    dr_d    = uop.dr_from_mem ? rdata : dr_q + 1'b1;

    pc_en   = uop.pc_from_ar | (uop.pc_skip & (dr_q == '0));
    pc_d    = uop.pc_from_ar ? ar_q : pc_q + 1'b1;

    ar_en   = accept | uop.ar_incr;
    ar_d    = accept ? start_addr : ar_q + 1'b1;

    case (uop.wsrc)
      WSRC_ACC: wdata = acc_q;
      WSRC_PC:  wdata = W'(pc_q);
      default:  wdata = dr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dr_q   <= '0;
      link_q <= 1'b0;
      pc_q   <= '0;
      ar_q   <= '0;
    end else begin
      if (acc_en)  acc_q  <= acc_d;
      if (dr_en)   dr_q   <= dr_d;
      if (link_en) link_q <= link_d;
      if (pc_en)   pc_q   <= pc_d;
      if (ar_en)   ar_q   <= ar_d;
    end
  end

  assign acc  = acc_q;
  assign dr   = dr_q;
  assign link = link_q;
  assign pc   = pc_q;
  assign ar   = ar_q;
endmodule

// File: rtl/mref_exec.sv
module mref_exec
  import mref_pkg::*;
#(
  parameter int WORD_BITS    = WORD_W,
  parameter int ADDR_BITS    = ADDR_W,
  parameter int MEM_IDX_BITS = 10,
  parameter int STEP_BITS    = SC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [OP_W-1:0]      start_op,
  input  logic [ADDR_BITS-1:0] start_addr,
  output logic                 done,
  output logic [STEP_BITS-1:0] step,
  output logic [WORD_BITS-1:0] acc,
  output logic [WORD_BITS-1:0] data_reg,
  output logic                 carry,
  output logic [ADDR_BITS-1:0] pc,
  output logic [ADDR_BITS-1:0] addr_reg,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata
);
  logic                 rst_sync_n;
  logic                 accept;
  uop_t                 uop;
  logic [OP_W-1:0]      cur_op;
  logic [WORD_BITS-1:0] rdata;

  mref_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mref_ctrl #(.SC_BITS(STEP_BITS), .OPB(OP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .start_op (start_op),
    .step     (step),
    .op       (cur_op),
    .accept   (accept),
    .uop      (uop)
  );

  mref_dp #(.W(WORD_BITS), .A(ADDR_BITS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .uop        (uop),
    .accept     (accept),
    .start_addr (start_addr),
    .rdata      (rdata),
    .acc        (acc),
    .dr         (data_reg),
    .link       (carry),
    .pc         (pc),
    .ar         (addr_reg),
    .wdata      (mem_wdata)
  );

  mref_mem #(.W(WORD_BITS), .IDX(MEM_IDX_BITS)) u_mem (
    .clk   (clk),
    .we    (uop.mem_wr),
    .idx   (addr_reg[MEM_IDX_BITS-1:0]),
    .wdata (mem_wdata),
    .rdata (rdata)
  );

  assign done     = uop.finish;
  assign mem_rd   = uop.mem_rd;
  assign mem_wr   = uop.mem_wr;
  assign mem_addr = addr_reg;
endmodule

// File: rtl/mref_exec_chk.sv
module mref_exec_chk #(
  parameter int WB = 16,
  parameter int AB = 12,
  parameter int SB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AB-1:0] start_addr,
  input logic          done,
  input logic [SB-1:0] step,
  input logic [WB-1:0] acc,
  input logic [WB-1:0] data_reg,
  input logic          carry,
  input logic [AB-1:0] pc,
  input logic [AB-1:0] addr_reg,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [WB-1:0] mem_wdata,
  input logic [2:0]    cur_op
);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && step == '0) |=> (step == SB'(4) && addr_reg == $past(start_addr)));

  a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (step == '0));

  a_r11_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0 && !done) |=> (step == $past(step) + 1'b1));

  a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_sum_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 3'd1) |=> ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(data_reg)})));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 3'd4) |=> (pc == $past(addr_reg)));

  a_r8_call_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (step == SB'(4) && cur_op == 3'd5) |-> (mem_wr && mem_wdata == WB'(pc)));

  a_r8_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 3'd5) |=> (pc == $past(addr_reg)));

  a_r9_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_op == 3'd6) |=>
      (pc == (($past(data_reg) == '0) ? $past(pc) + 1'b1 : $past(pc))));

  a_r10_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
    (step == SB'(4) && cur_op == 3'd7) |-> (done && !mem_wr && !mem_rd));

endmodule

bind mref_exec mref_exec_chk #(.WB(WORD_BITS), .AB(ADDR_BITS), .SB(STEP_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .start_addr (start_addr),
  .done       (done),
  .step       (step),
  .acc        (acc),
  .data_reg   (data_reg),
  .carry      (carry),
  .pc         (pc),
  .addr_reg   (addr_reg),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_wdata  (mem_wdata),
  .cur_op     (cur_op)
);

// File: tb/sim_mref_exec.sv
`timescale 1ns/1ps
module sim_mref_exec;
  localparam int W  = 16;
  localparam int A  = 12;
  localparam int IX = 10;
  localparam int S  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   start_op = '0;
  logic [A-1:0] start_addr = '0;

  logic         done, carry, mem_rd, mem_wr;
  logic [S-1:0] step;
  logic [W-1:0] acc, data_reg, mem_wdata;
  logic [A-1:0] pc, addr_reg, mem_addr;

  mref_exec u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op), .start_addr(start_addr),
    .done(done), .step(step), .acc(acc), .data_reg(data_reg), .carry(carry), .pc(pc),
    .addr_reg(addr_reg), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit checking = 0;

  // behavioural reference model
  logic [W-1:0] m_acc, m_dr;
  logic         m_carry;
  logic [A-1:0] m_pc, m_ar;
  logic [S-1:0] m_step;
  logic [2:0]   m_op;
  logic [W-1:0] m_mem [int];
  logic [W:0]   m_sum;
  bit           m_end;

  function automatic int slot(input logic [A-1:0] a);
    return int'(a) % (1 << IX);
  endfunction

  function automatic bit exp_done();
    if (m_step == 0) return 0;
    case (m_op)
      3'd0, 3'd1, 3'd2, 3'd5: return m_step == 5;
      3'd6:                   return m_step == 6;
      default:                return m_step == 4;
    endcase
  endfunction

  function automatic bit exp_rd();
    return m_step == 4 && (m_op == 0 || m_op == 1 || m_op == 2 || m_op == 6);
  endfunction

  function automatic bit exp_wr();
    return (m_step == 4 && (m_op == 3 || m_op == 5)) || (m_step == 6 && m_op == 6);
  endfunction

  function automatic logic [W-1:0] exp_wdata();
    if (m_op == 3) return m_acc;
    if (m_op == 5) return W'(m_pc);
    return m_dr;
  endfunction

  function automatic string tag_of();
    if (m_step == 0) return "R2";
    case (m_op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_dr = '0; m_carry = 1'b0; m_pc = '0; m_ar = '0; m_step = '0; m_op = '0;
    end else if (m_step == 0) begin
      if (start) begin
        m_step = S'(4); m_op = start_op; m_ar = start_addr;
      end
    end else begin
      m_end = 0;
      case (m_op)
        3'd0, 3'd1, 3'd2: begin
          if (m_step == 4) m_dr = m_mem[slot(m_ar)];
          else begin
            if (m_op == 0) m_acc = m_acc & m_dr;
            else if (m_op == 1) begin
              m_sum = {1'b0, m_acc} + {1'b0, m_dr};
              m_acc = m_sum[W-1:0]; m_carry = m_sum[W];
            end else m_acc = m_dr;
            m_end = 1;
          end
        end
        3'd3: begin m_mem[slot(m_ar)] = m_acc; m_end = 1; end
        3'd4: begin m_pc = m_ar; m_end = 1; end
        3'd5: begin
          if (m_step == 4) begin m_mem[slot(m_ar)] = W'(m_pc); m_ar = m_ar + 1'b1; end
          else begin m_pc = m_ar; m_end = 1; end
        end
        3'd6: begin
          if (m_step == 4) m_dr = m_mem[slot(m_ar)];
          else if (m_step == 5) m_dr = m_dr + 1'b1;
          else begin
            m_mem[slot(m_ar)] = m_dr;
            if (m_dr == 0) m_pc = m_pc + 1'b1;
            m_end = 1;
          end
        end
        default: m_end = 1;
      endcase
      m_step = m_end ? S'(0) : m_step + 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      chk("R11", "step",      W'(step),     W'(m_step));
      chk("R11", "done",      W'(done),     W'(exp_done()));
      chk(tag_of(), "acc",      acc,        m_acc);
      chk(tag_of(), "data_reg", data_reg,   m_dr);
      chk(tag_of(), "carry",    W'(carry),  W'(m_carry));
      chk(tag_of(), "pc",       W'(pc),     W'(m_pc));
      chk(tag_of(), "addr_reg", W'(addr_reg), W'(m_ar));
      chk(tag_of(), "mem_rd",   W'(mem_rd), W'(exp_rd()));
      chk(tag_of(), "mem_wr",   W'(mem_wr), W'(exp_wr()));
      chk("R12", "mem_addr",  W'(mem_addr), W'(m_ar));
      chk("R13", "rd_and_wr", W'(mem_rd & mem_wr), '0);
      if (exp_wr()) chk(tag_of(), "mem_wdata", mem_wdata, exp_wdata());
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic issue(input logic [2:0] o, input logic [A-1:0] a, input bit poke);
    @(negedge clk); start = 1'b1; start_op = o; start_addr = a;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      @(negedge clk); start = 1'b1; start_op = 3'd4; start_addr = 12'h777;
      @(negedge clk); start = 1'b0;
    end
    for (int n = 0; n < 16 && m_step != 0; n++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checking = 1;
    // R1: state held at zero in reset
    chk("R1", "reset acc",  acc, '0);
    chk("R1", "reset pc",   W'(pc), '0);
    chk("R1", "reset step", W'(step), '0);
    chk("R1", "reset done", W'(done), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(3'd4, 12'h00F, 0);                 // R7 jump
    issue(3'd5, 12'h010, 0);                 // R8 call stores 0x00F
    issue(3'd2, 12'h010, 0);                 // R5 load
    issue(3'd4, 12'hFFF, 0);
    issue(3'd5, 12'h020, 0);                 // stores 0x0FFF
    issue(3'd2, 12'h020, 0);
    for (int i = 0; i < 4; i++) begin
      issue(3'd3, 12'h030, 0);               // R6 store
      issue(3'd1, 12'h030, 0);               // R4 doubling
    end
    issue(3'd1, 12'h010, 0);                 // 0xFFFF
    issue(3'd3, 12'h040, 0);
    issue(3'd1, 12'h010, 0);                 // R4 carry out
    chk("R4", "carry after overflow", W'(carry), 16'h0001);
    chk("R4", "sum after overflow",   acc,       16'h000E);
    issue(3'd0, 12'h020, 0);                 // R3 mask
    issue(3'd2, 12'h040, 0);
    issue(3'd0, 12'h010, 0);
    chk("R3", "mask result", acc, 16'h000F);
    issue(3'd6, 12'h040, 1);                 // R9 wrap to zero and skip, R2 poke ignored
    chk("R2", "busy start ignored", W'(addr_reg), 16'h0040);
    chk("R9", "skip taken", W'(pc), 16'h0022);
    issue(3'd6, 12'h040, 0);                 // R9 no skip
    issue(3'd2, 12'h040, 0);
    chk("R9", "incremented word", acc, 16'h0001);
    issue(3'd7, 12'h050, 0);                 // R10 unused code
    chk("R10", "unused leaves pc", W'(pc), 16'h0022);
    issue(3'd5, 12'hFFF, 0);                 // R8 address wrap
    chk("R8", "call wrap pc", W'(pc), 16'h0000);
    issue(3'd1, 12'h010, 0);
    issue(3'd3, 12'h405, 0);                 // R12 aliases index 5
    issue(3'd2, 12'h020, 0);
    issue(3'd2, 12'h005, 0);
    chk("R12", "aliased read", acc, 16'h0010);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule